// File: doc/BRIEF.md
# DRAM Idle Power Mode Controller

This block decides, for each idle period of a DRAM channel, how the memory spends that idle time: in precharge power-down, in self-refresh, or in a mix of the two. When the channel goes idle and all banks are precharged, the controller first issues power-down. It then waits for a programmable time-out. After the time-out it asks an external idle-length predictor how long the whole idle period will last. If the answer is long enough for self-refresh to pay off, it switches to self-refresh. It also schedules the self-refresh exit so that power-up finishes exactly at the predicted end of the idle period.

When the controller reaches that planned exit point, it asks the predictor again, passing the elapsed idle time. If the new forecast still justifies self-refresh, the memory stays in one unbroken self-refresh period. This repeats up to a parameterised number of forecasts per idle period. Idle cycles that self-refresh does not cover use power-down. These include the time-out, periods judged too short, and any time left after a completed exit.

A request that arrives while the memory is in a low-power state waits with `ready_o` low until the exit finishes. A counter accumulates the cycles lost this way as wake-up penalty.

Top module: `dram_idle_pm`

## Requirements
- R1: After reset `ready_o` is 1, all four command outputs are 0 and `penalty_o` is 0. The block leaves the awake state only in a cycle where `req_i` is 0 and `idle_i` (all banks precharged) is 1. It then shows `pd_enter_o` in the first low-power cycle, and with `idle_i` at 0 it stays awake.
- R2: Idle cycles are numbered from 1, the first low-power cycle being 1. With time-out T (T = 0 allowed), `pred_req_o` first rises in idle cycle T+1. `pred_elapsed_o` carries the current idle-cycle number, and `pred_req_o` stays high until `pred_ack_i` or a request.
- R3: A forecast L (total idle cycles, taken at an edge with `pred_ack_i` = 1 in idle cycle E) selects self-refresh only when L >= SRT and L > E + SR_EXIT. `sr_enter_o` then appears in the next cycle. Otherwise the memory stays in power-down for the rest of the period, with no further forecasts.
- R4: With no further forecast allowed, `sr_exit_o` appears in idle cycle L - SR_EXIT + 1, and the exit ends after idle cycle L.
- R5: On reaching the planned exit point with forecasts left, a new forecast is requested. A worthwhile forecast keeps self-refresh without any command. Otherwise `sr_exit_o` is issued in the cycle after the acknowledge.
- R6: No more than MAX_PRED forecasts are taken in one idle period.
- R7: When a self-refresh exit completes with no request pending, `pd_enter_o` is issued and the memory stays in power-down until a request arrives.
- R8: A request in power-down causes `pd_exit_o` and PD_EXIT exit cycles. A request in self-refresh causes `sr_exit_o` and SR_EXIT exit cycles. `ready_o` is 1 exactly in the awake state.
- R9: `penalty_o` grows by one for every exit cycle in which `req_i` is 1. A request that arrives during a self-refresh exit therefore adds only the exit cycles still remaining.
- R10: A request has priority over a pending forecast: `pred_req_o` falls and the exit starts without waiting for `pred_ack_i`.
- R11: The four command outputs are single-cycle pulses, and no two are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | All banks precharged, channel may sleep |
| req_i | input | 1 | Access pending; held until served |
| timeout_i | input | TW | Idle cycles to wait before the first forecast |
| pred_req_o | output | 1 | Forecast request |
| pred_elapsed_o | output | CW | Current idle-cycle number for the predictor |
| pred_ack_i | input | 1 | Forecast valid |
| pred_cycles_i | input | CW | Forecast total idle length in cycles |
| pd_enter_o | output | 1 | Enter power-down pulse |
| pd_exit_o | output | 1 | Exit power-down pulse |
| sr_enter_o | output | 1 | Enter self-refresh pulse |
| sr_exit_o | output | 1 | Exit self-refresh pulse |
| ready_o | output | 1 | Memory powered and accessible |
| penalty_o | output | PW | Accumulated wake-up penalty cycles |

## Verification
Every cycle, the embedded properties check several rules. No two commands are high at once. Self-refresh entry always follows a forecast of at least SRT. Low-power entry happens only from a precharged, request-free cycle. `ready_o` returns only out of an exit. The penalty and exit counters move in single steps, and forecasts never exceed the cap. Only the bench scenarios can show the timing relations: the exit placed so that it ends at the forecast end, re-forecast chaining up to the cap, the boundary cases of the gain rule, the power-down tail, and the partial penalty of a request that lands mid-exit. The bench checks these against its own cycle model and against hand-computed cycle numbers.

// File: rtl/dip_pkg.sv
package dip_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE   = 3'd0,
    ST_PD      = 3'd1,
    ST_PD_ASK  = 3'd2,
    ST_SR      = 3'd3,
    ST_SR_ASK  = 3'd4,
    ST_SR_WAKE = 3'd5,
    ST_PD_WAKE = 3'd6
  } pm_state_e;

  typedef struct packed {
    logic pd_enter;
    logic pd_exit;
    logic sr_enter;
    logic sr_exit;
  } pm_cmd_t;

endpackage

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  output logic [CW-1:0] elapsed_o
);
  localparam logic [CW-1:0] EL_MAX = '1;

  logic [CW-1:0] el_q, el_d;
  logic          el_en;

  always_comb begin
    el_d  = el_q;
    el_en = 1'b0;
    if (start_i) begin
      el_d  = CW'(1);
      el_en = 1'b1;
    end else if (run_i && (el_q != EL_MAX)) begin
      el_d  = el_q + 1'b1;
      el_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     el_q <= '0;
    else if (el_en) el_q <= el_d;
  end

  assign elapsed_o = el_q;

  // R2
  el_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && run_i && el_q != EL_MAX) |=> (el_q == $past(el_q) + 1'b1));

endmodule

// File: rtl/pm_wake_counter.sv
module pm_wake_counter #(
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [EW-1:0] load_val_i,
  output logic          last_o
);
  logic [EW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == EW'(1));

  // R8
  wake_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pm_penalty_counter.sv
module pm_penalty_counter #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  output logic [PW-1:0] count_o
);
  localparam logic [PW-1:0] P_MAX = '1;

  logic [PW-1:0] pen_q, pen_d;
  logic          pen_en;

  always_comb begin
    pen_en = inc_i && (pen_q != P_MAX);
    pen_d  = pen_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pen_q <= '0;
    else if (pen_en) pen_q <= pen_d;
  end

  assign count_o = pen_q;

  // R9
  pen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_q != $past(pen_q)) |-> (pen_q == $past(pen_q) + 1'b1 && $past(inc_i)));

endmodule

// File: rtl/dram_idle_pm.sv
module dram_idle_pm #(
  parameter int SRT      = 3691,
  parameter int SR_EXIT  = 512,
  parameter int PD_EXIT  = 10,
  parameter int MAX_PRED = 64,
  parameter int CW       = 24,
  parameter int TW       = 16,
  parameter int PW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          req_i,
  input  logic [TW-1:0] timeout_i,
  output logic          pred_req_o,
  output logic [CW-1:0] pred_elapsed_o,
  input  logic          pred_ack_i,
  input  logic [CW-1:0] pred_cycles_i,
  output logic          pd_enter_o,
  output logic          pd_exit_o,
  output logic          sr_enter_o,
  output logic          sr_exit_o,
  output logic          ready_o,
  output logic [PW-1:0] penalty_o
);
  import dip_pkg::*;

  localparam int            WMAX   = (SR_EXIT > PD_EXIT) ? SR_EXIT : PD_EXIT;
  localparam int            EW     = $clog2(WMAX + 1);
  localparam int            NW     = $clog2(MAX_PRED + 1);
  localparam logic [CW:0]   SRT_X  = (CW+1)'(SRT);
  localparam logic [CW:0]   SRX_X  = (CW+1)'(SR_EXIT);
  localparam logic [CW-1:0] SRX_C  = CW'(SR_EXIT);
  localparam logic [EW-1:0] SRX_W  = EW'(SR_EXIT);
  localparam logic [EW-1:0] PDX_W  = EW'(PD_EXIT);
  localparam logic [NW-1:0] MAXP_W = NW'(MAX_PRED);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  pm_state_e       state_q, state_d;
  logic            tmo_q, tmo_d;
  logic [NW-1:0]   npred_q, npred_d;
  logic [CW-1:0]   xpt_q, xpt_d;
  pm_cmd_t         cmd_q, cmd_d;

  logic            t_start, w_load, w_last, go_srw, go_pdw;
  logic [EW-1:0]   w_val;
  logic [CW-1:0]   elapsed;
  logic            gain, tmo_hit, at_xpt, pen_inc;
  logic [CW-1:0]   xpt_new;

  pm_idle_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start_i   (t_start),
    .run_i     (state_q != ST_AWAKE),
    .elapsed_o (elapsed)
  );

  pm_wake_counter #(.EW(EW)) u_wake (
    .clk        (clk),
    .rst_n      (rst_ns),
    .load_i     (w_load),
    .load_val_i (w_val),
    .last_o     (w_last)
  );

  assign pen_inc = req_i && (state_q == ST_SR_WAKE || state_q == ST_PD_WAKE);

  pm_penalty_counter #(.PW(PW)) u_pen (
    .clk     (clk),
    .rst_n   (rst_ns),
    .inc_i   (pen_inc),
    .count_o (penalty_o)
  );

  // gain rule: long enough for self-refresh and room to place the exit
  always_comb begin
    gain    = ({1'b0, pred_cycles_i} >= SRT_X) &&
              ({1'b0, pred_cycles_i} > ({1'b0, elapsed} + SRX_X));
    xpt_new = pred_cycles_i - SRX_C;
    tmo_hit = elapsed >= CW'(timeout_i);
    at_xpt  = elapsed >= xpt_q;
  end

  always_comb begin
    state_d = state_q;
    tmo_d   = tmo_q;
    npred_d = npred_q;
    xpt_d   = xpt_q;
    cmd_d   = '0;
    t_start = 1'b0;
    go_srw  = 1'b0;
    go_pdw  = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (!req_i && idle_i) begin
          t_start        = 1'b1;
          npred_d        = '0;
          cmd_d.pd_enter = 1'b1;
          if (timeout_i == '0) begin
            state_d = ST_PD_ASK;
            tmo_d   = 1'b0;
          end else begin
            state_d = ST_PD;
            tmo_d   = 1'b1;
          end
        end
      end
      ST_PD: begin
        if (req_i) go_pdw = 1'b1;
        else if (tmo_q && tmo_hit) begin
          state_d = ST_PD_ASK;
          tmo_d   = 1'b0;
        end
      end
      ST_PD_ASK: begin
        if (req_i) go_pdw = 1'b1;
        else if (pred_ack_i) begin
          npred_d = npred_q + 1'b1;
          if (gain) begin
            state_d        = ST_SR;
            xpt_d          = xpt_new;
            cmd_d.sr_enter = 1'b1;
          end else begin
            state_d = ST_PD;
          end
        end
      end
      ST_SR: begin
        if (req_i) go_srw = 1'b1;
        else if (at_xpt) begin
          if (npred_q < MAXP_W) state_d = ST_SR_ASK;
          else                  go_srw  = 1'b1;
        end
      end
      ST_SR_ASK: begin
        if (req_i) go_srw = 1'b1;
        else if (pred_ack_i) begin
          npred_d = npred_q + 1'b1;
          if (gain) begin
            state_d = ST_SR;
            xpt_d   = xpt_new;
          end else begin
            go_srw = 1'b1;
          end
        end
      end
      ST_SR_WAKE: begin
        if (w_last) begin
          if (req_i) state_d = ST_AWAKE;
          else begin
            state_d        = ST_PD;
            tmo_d          = 1'b0;
            cmd_d.pd_enter = 1'b1;
          end
        end
      end
      ST_PD_WAKE: begin
        if (w_last) state_d = ST_AWAKE;
      end
      default: state_d = ST_AWAKE;
    endcase
    if (go_srw) begin
      state_d       = ST_SR_WAKE;
      cmd_d.sr_exit = 1'b1;
    end
    if (go_pdw) begin
      state_d       = ST_PD_WAKE;
      cmd_d.pd_exit = 1'b1;
    end
  end

  always_comb begin
    w_load = go_srw || go_pdw;
    w_val  = go_srw ? SRX_W : PDX_W;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_AWAKE;
      tmo_q   <= 1'b0;
      npred_q <= '0;
      xpt_q   <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      tmo_q   <= tmo_d;
      npred_q <= npred_d;
      xpt_q   <= xpt_d;
      cmd_q   <= cmd_d;
    end
  end

  assign ready_o        = (state_q == ST_AWAKE);
  assign pred_req_o     = (state_q == ST_PD_ASK) || (state_q == ST_SR_ASK);
  assign pred_elapsed_o = elapsed;
  assign pd_enter_o     = cmd_q.pd_enter;
  assign pd_exit_o      = cmd_q.pd_exit;
  assign sr_enter_o     = cmd_q.sr_enter;
  assign sr_exit_o      = cmd_q.sr_exit;

  // R11
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({pd_enter_o, pd_exit_o, sr_enter_o, sr_exit_o}));

  // R3
  sr_gain_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sr_enter_o |-> ($past(pred_ack_i) && ($past(pred_cycles_i) >= CW'(SRT))));

  // R1
  entry_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (pd_enter_o && $past(ready_o)) |-> ($past(idle_i) && !$past(req_i)));

  // R8
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(ready_o) |-> ($past(state_q) == ST_SR_WAKE || $past(state_q) == ST_PD_WAKE));

  // R10
  ask_sleep_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pred_req_o |-> !ready_o);

  // R6
  pred_cap_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    npred_q <= MAXP_W);

endmodule

// File: tb/test_dram_idle_pm.sv
module test_dram_idle_pm;
  localparam int SRT = 40, SRX = 8, PDX = 3, MAXP = 3, CW = 16, TW = 8, PW = 16;

  logic clk = 1'b0, rst_n = 1'b0, idle = 1'b1, req = 1'b1, ack = 1'b0;
  logic [TW-1:0] to = '0;
  logic [CW-1:0] pc = '0;
  logic pred_req, pde, pdx, sre, srx, ready;
  logic [CW-1:0] pel;
  logic [PW-1:0] pen;

  dram_idle_pm #(.SRT(SRT), .SR_EXIT(SRX), .PD_EXIT(PDX), .MAX_PRED(MAXP),
                 .CW(CW), .TW(TW), .PW(PW)) i_dram_idle_pm (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .req_i(req), .timeout_i(to),
    .pred_req_o(pred_req), .pred_elapsed_o(pel), .pred_ack_i(ack),
    .pred_cycles_i(pc), .pd_enter_o(pde), .pd_exit_o(pdx), .sr_enter_o(sre),
    .sr_exit_o(srx), .ready_o(ready), .penalty_o(pen));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int AW = 0, LP = 1, LPQ = 2, SR = 3, SRQ = 4, SRW = 5, LPW = 6;
  int md, el, np, xp, cnt, mpen, ecmd;
  bit tmo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = AW; el = 0; np = 0; xp = 0; cnt = 0; mpen = 0; ecmd = 0; tmo = 0;
    end else begin
      int nel;
      bit inc, good, wake_sr, wake_pd;
      inc = req && (md == SRW || md == LPW);
      nel = (md != AW) ? el + 1 : el;
      good = (int'(pc) >= SRT) && (int'(pc) > el + SRX);
      wake_sr = 0; wake_pd = 0; ecmd = 0;
      if (md == AW) begin
        if (!req && idle) begin
          ecmd = 8; np = 0; nel = 1;
          if (to == 0) begin md = LPQ; tmo = 0; end else begin md = LP; tmo = 1; end
        end
      end else if (md == LP) begin
        if (req) wake_pd = 1;
        else if (tmo && el >= int'(to)) begin md = LPQ; tmo = 0; end
      end else if (md == LPQ) begin
        if (req) wake_pd = 1;
        else if (ack) begin
          np++;
          if (good) begin md = SR; xp = int'(pc) - SRX; ecmd = 2; end else md = LP;
        end
      end else if (md == SR) begin
        if (req) wake_sr = 1;
        else if (el >= xp) begin if (np < MAXP) md = SRQ; else wake_sr = 1; end
      end else if (md == SRQ) begin
        if (req) wake_sr = 1;
        else if (ack) begin
          np++;
          if (good) begin md = SR; xp = int'(pc) - SRX; end else wake_sr = 1;
        end
      end else if (md == SRW) begin
        if (cnt == 1) begin
          if (req) md = AW; else begin md = LP; tmo = 0; ecmd = 8; end
        end
        cnt = (cnt > 0) ? cnt - 1 : 0;
      end else begin
        if (cnt == 1) md = AW;
        cnt = (cnt > 0) ? cnt - 1 : 0;
      end
      if (wake_sr) begin md = SRW; cnt = SRX; ecmd = 1; end
      if (wake_pd) begin md = LPW; cnt = PDX; ecmd = 4; end
      el = nel;
      if (inc) mpen++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk(ready == (md == AW), "R8 ready", ready, md == AW);
    chk({pde, pdx, sre, srx} == 4'(ecmd), "R11 commands", {pde, pdx, sre, srx}, ecmd);
    chk(pred_req == (md == LPQ || md == SRQ), "R2 pred_req", pred_req, md == LPQ || md == SRQ);
    if (pred_req) chk(int'(pel) == el, "R2 pred_elapsed", pel, el);
    chk(int'(pen) == mpen, "R9 penalty", pen, mpen);
  end

  // predictor stub
  int predq[$];
  int dly = 0, wt = 0, n_ack = 0;
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (pred_req) begin
      if (wt >= dly) begin
        ack = 1'b1; wt = 0; n_ack++;
        pc = (predq.size() > 0) ? CW'(predq.pop_front()) : '0;
      end else wt++;
    end else wt = 0;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one idle period: returns penalty delta and records events by idle cycle
  int n_sre, first_srx, last_pde, first_ask, ask_el;
  task automatic episode(input int tmo_v, input int reqk, output int delta);
    int k, p0;
    to = TW'(tmo_v); p0 = int'(pen);
    n_sre = 0; first_srx = 0; last_pde = 0; first_ask = 0; ask_el = 0; n_ack = 0;
    req = 1'b0; k = 0;
    while (k < reqk) begin
      @(negedge clk); k++;
      if (sre) n_sre++;
      if (srx && first_srx == 0) first_srx = k;
      if (pde) last_pde = k;
      if (pred_req && first_ask == 0) begin first_ask = k; ask_el = int'(pel); end
    end
    req = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    delta = int'(pen) - p0;
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && {pde, pdx, sre, srx} == 4'b0 && pen == '0, "R1 reset state", ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: not precharged -> stays awake
    begin
      int seen = 0, lowrdy = 0;
      idle = 1'b0; req = 1'b0;
      repeat (10) begin @(negedge clk); if (pde) seen++; if (!ready) lowrdy++; end
      chk(seen == 0 && lowrdy == 0, "R1 idle_i low ignored", seen + lowrdy, 0);
      idle = 1'b1; req = 1'b1;
      @(negedge clk);
    end

    // request before time-out: plain power-down
    predq.delete(); episode(5, 3, d);
    chk(d == PDX, "R8 power-down exit penalty", d, PDX);
    chk(n_ack == 0, "R2 no forecast before time-out", n_ack, 0);
    chk(last_pde == 1, "R1 pd_enter in first idle cycle", last_pde, 1);

    // short forecast rejected
    predq = '{20}; episode(4, 30, d);
    chk(n_sre == 0, "R3 short forecast keeps power-down", n_sre, 0);
    chk(n_ack == 1, "R3 no further forecasts", n_ack, 1);
    chk(first_ask == 5, "R2 forecast asked in cycle T+1", first_ask, 5);

    // boundary L == SRT accepted, re-forecast not worthwhile
    predq = '{40, 0}; episode(0, 60, d);
    chk(n_sre == 1, "R3 L equal to SRT selects self-refresh", n_sre, 1);
    chk(first_srx == 34, "R5 exit after unworthy re-forecast", first_srx, 34);
    chk(last_pde == 42, "R7 power-down after exit", last_pde, 42);
    chk(d == PDX, "R7 tail power-down exit penalty", d, PDX);

    // boundary L == SRT-1 rejected
    predq = '{39}; episode(0, 20, d);
    chk(n_sre == 0, "R3 L below SRT rejected", n_sre, 0);

    // room rule: L must exceed E + SR_EXIT
    predq = '{50}; episode(45, 60, d);
    chk(n_sre == 0, "R3 no room for exit", n_sre, 0);
    chk(first_ask == 46 && ask_el == 46, "R2 elapsed given with forecast", ask_el, 46);

    // chained forecasts up to the cap, just-in-time exit
    predq = '{60, 100, 150, 999}; episode(0, 170, d);
    chk(n_sre == 1, "R5 one unbroken self-refresh", n_sre, 1);
    chk(n_ack == MAXP, "R6 forecast cap", n_ack, MAXP);
    chk(first_srx == 143, "R4 exit placed at L-SR_EXIT+1", first_srx, 143);
    chk(last_pde == 151, "R7 power-down after final exit", last_pde, 151);

    // request during self-refresh
    predq = '{200}; episode(0, 20, d);
    chk(d == SRX, "R9 full self-refresh exit penalty", d, SRX);

    // request during exit
    predq = '{60, 0}; episode(0, 57, d);
    chk(d == 5, "R9 partial penalty mid-exit", d, 5);

    // request while forecast pending
    dly = 50; predq = '{100}; episode(2, 10, d);
    chk(n_ack == 0, "R10 request overrides pending forecast", n_ack, 0);
    chk(d == PDX, "R10 exit started at once", d, PDX);
    dly = 0;

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule